// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block turns a fast system clock into an 8 kHz frame marker. A phase counter divides the system clock by a parameter `DIV`, which equals the system clock frequency divided by 8 kHz. A registered output stage turns the counter phase into either a 50:50 square wave or a narrow pulse. The marker can be enabled, disabled or inverted. In pulse mode the pulse lasts exactly one period of a slower secondary output clock. That clock reaches the block as a one-cycle enable strobe, `aux_tick`. A configuration bit places the pulse at the rising-edge or the falling-edge position of the equivalent square wave.

An external frame strobe can re-phase the counter. The strobe acts only while its enable is high. When it acts, the counter restarts at its frame-start value, so later frame boundaries line up with the external frame. Any pending or active pulse is discarded at the same time.

Top module: `fsync_gen`

## Requirements
- R1: The frame period is exactly `DIV` system clock cycles. With no qualified resync, the output waveform repeats every `DIV` cycles.
- R2: In square mode (`fs_pulse`=0), the output before inversion is high for the first `DIV/2` cycles of each frame and low for the rest. The output is registered: the cycle in which the counter sits at frame start is seen on `fsync` one clock later.
- R3: While `fs_en` is 0, `fsync` equals `fs_inv`. The inactive level is 0 before inversion, so `fsync` is 0 when `fs_inv` is 0 and 1 when `fs_inv` is 1.
- R4: When `fs_inv` is 1, `fsync` is the bitwise complement of the waveform produced with `fs_inv` at 0. Inversion is applied after mode and position selection.
- R5: In pulse mode (`fs_pulse`=1), the pulse is raised on the first `aux_tick` at or after the selected edge position. It lowers on the next `aux_tick`, so it lasts one secondary-clock period. `fsync` shows it one cycle after the internal pulse.
- R6: `fs_at_fall`=0 places the pulse at frame start, the rising-edge position of the square wave. `fs_at_fall`=1 places it at counter value `DIV/2`, the falling-edge position.
- R7: An `ext_sync` strobe with `ext_sync_en`=1 sets the counter to frame start in the next cycle. It also cancels any pending or active pulse.
- R8: An `ext_sync` strobe with `ext_sync_en`=0 leaves the frame phase unchanged.
- R9: Reset is synchronous and active-high. During and after reset `fsync` is 0 and the counter is at frame start, whatever the values of `fs_en` and `fs_inv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_en | input | 1 | Enables the frame sync waveform |
| fs_inv | input | 1 | Inverts the output polarity |
| fs_pulse | input | 1 | 0 = square wave, 1 = pulse mode |
| fs_at_fall | input | 1 | Pulse position: 0 = frame start, 1 = mid-frame |
| aux_tick | input | 1 | One-cycle strobe per secondary-clock period |
| ext_sync | input | 1 | External frame-start strobe |
| ext_sync_en | input | 1 | Allows `ext_sync` to re-phase the counter |
| fsync | output | 1 | Frame sync output |

## Verification
The hardest situation to reach is a pulse whose edge position does not land on an `aux_tick`. Its start must then wait for the next tick, and because `DIV` is not a multiple of the tick period, that wait differs from frame to frame. The stimulus runs ticks every 6 cycles against a 40-cycle frame. Each case checks two consecutive frames cycle by cycle against a model built from the tick schedule and the resync instant. A second resync strobe, with the enable set or cleared, tests whether the phase moves or stays put.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic {
    FS_SQUARE = 1'b0,
    FS_PULSED = 1'b1
  } fs_shape_e;
endpackage

// File: rtl/fsg_phase_ctr.sv
module fsg_phase_ctr #(
  parameter int DIV = 19440
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reload,
  output logic [$clog2(DIV)-1:0] cnt,
  output logic                   at_start,
  output logic                   at_mid,
  output logic                   first_half
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(DIV / 2);

  always_ff @(posedge clk) begin
    if (rst || reload)      cnt <= '0;
    else if (cnt == LAST_C) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  assign at_start   = (cnt == '0);
  assign at_mid     = (cnt == HALF_C);
  assign first_half = (cnt < HALF_C);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_C); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!reload && cnt == LAST_C) |=> (cnt == '0)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!reload && cnt != LAST_C) |=> (cnt == $past(cnt) + CW'(1))); // R1
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == '0)); // R7
endmodule

// File: rtl/fsg_pulse_shaper.sv
module fsg_pulse_shaper (
  input  logic clk,
  input  logic rst,
  input  logic edge_hit,
  input  logic tick,
  input  logic flush,
  output logic pulse
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pulse <= 1'b0;
      armed <= 1'b0;
    end else if (tick) begin
      if (pulse) begin
        pulse <= 1'b0;
        armed <= edge_hit | armed;
      end else begin
        pulse <= edge_hit | armed;
        armed <= 1'b0;
      end
    end else if (edge_hit) begin
      armed <= 1'b1;
    end
  end

  AST_PULSE_DROP: assert property (@(posedge clk) disable iff (rst)
    (pulse && tick && !flush) |=> !pulse); // R5
  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!tick && !flush) |=> (pulse == $past(pulse))); // R5
  AST_PULSE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!pulse && !armed)); // R7
endmodule

// File: rtl/fsg_out_stage.sv
module fsg_out_stage
  import fsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      inv,
  input  fs_shape_e shape,
  input  logic      square,
  input  logic      pulse,
  output logic      out
);
  logic shaped;

  always_comb begin
    if (!en)                    shaped = 1'b0;
    else if (shape == FS_PULSED) shaped = pulse;
    else                        shaped = square;
  end

  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else     out <= shaped ^ inv;
  end

  AST_OUT_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (out == $past(inv))); // R3
  AST_OUT_RESET: assert property (@(posedge clk)
    rst |=> (out == 1'b0)); // R9
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsg_pkg::*;
#(
  parameter int DIV = 19440
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_en,
  input  logic fs_inv,
  input  logic fs_pulse,
  input  logic fs_at_fall,
  input  logic aux_tick,
  input  logic ext_sync,
  input  logic ext_sync_en,
  output logic fsync
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);

  logic [CW-1:0] ctr_cnt;
  logic          at_start, at_mid, first_half;
  logic          reload, edge_hit, pulse;
  fs_shape_e     shape;

  assign reload   = ext_sync & ext_sync_en;
  assign edge_hit = fs_at_fall ? at_mid : at_start;
  assign shape    = fs_pulse ? FS_PULSED : FS_SQUARE;

  fsg_phase_ctr #(.DIV(DIV)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .reload     (reload),
    .cnt        (ctr_cnt),
    .at_start   (at_start),
    .at_mid     (at_mid),
    .first_half (first_half)
  );

  fsg_pulse_shaper u_shp (
    .clk      (clk),
    .rst      (rst),
    .edge_hit (edge_hit),
    .tick     (aux_tick),
    .flush    (reload),
    .pulse    (pulse)
  );

  fsg_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .en     (fs_en),
    .inv    (fs_inv),
    .shape  (shape),
    .square (first_half),
    .pulse  (pulse),
    .out    (fsync)
  );

  AST_RESYNC_GATED: assert property (@(posedge clk) disable iff (rst)
    (ext_sync && !ext_sync_en && ctr_cnt != LAST_C) |=> (ctr_cnt != '0)); // R8
  AST_RESET_PHASE: assert property (@(posedge clk)
    rst |=> (ctr_cnt == '0)); // R9
endmodule

// File: tb/sim_fsync_gen.sv
`timescale 1ns/1ps
module sim_fsync_gen;
  localparam int DIV  = 40;
  localparam int HALF = DIV / 2;
  localparam int T2   = 6;
  localparam int NV   = 10;
  // {en, inv, pulse, at_fall, qualified second strobe}
  localparam logic [4:0] VEC [NV] = '{
    5'b10001, 5'b11001, 5'b10101, 5'b10111, 5'b11110,
    5'b10000, 5'b00101, 5'b01001, 5'b11101, 5'b10110
  };

  logic clk = 0, rst = 1;
  logic fs_en = 0, fs_inv = 0, fs_pulse = 0, fs_at_fall = 0;
  logic aux_tick = 0, ext_sync = 0, ext_sync_en = 0;
  logic fsync;
  int cyc = 0, total = 0, passed = 0;

  fsync_gen #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .fs_en(fs_en), .fs_inv(fs_inv), .fs_pulse(fs_pulse),
    .fs_at_fall(fs_at_fall), .aux_tick(aux_tick), .ext_sync(ext_sync),
    .ext_sync_en(ext_sync_en), .fsync(fsync)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    aux_tick = ((cyc + 1) % T2 == 0);
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: fsync=%b expected %b at cycle %0d", req, act, exp, cyc);
  endtask

  task automatic strobe(input logic q, output int r);
    @(negedge clk);
    ext_sync = 1; ext_sync_en = q; r = cyc + 1;
    @(negedge clk);
    ext_sync = 0; ext_sync_en = 0;
  endtask

  task automatic wait_to(input int m);
    while (cyc < m) @(negedge clk);
  endtask

  function automatic logic exp_out(int m, int rf, logic en, logic inv, logic pm, logic fall);
    logic v = 1'b0;
    if (en) begin
      if (!pm) v = (((m - rf - 1) % DIV) < HALF);
      else for (int k = 0; k < 4; k++) begin
        int e = rf + 1 + (fall ? HALF : 0) + k * DIV;
        int t = ((e + T2 - 1) / T2) * T2;
        if (m >= t + 1 && m <= t + T2) v = 1'b1;
      end
    end
    return v ^ inv;
  endfunction

  initial begin
    #(200000 * 5);
    total++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    int r1, r2, rf;
    string tag;
    fs_inv = 1; fs_en = 1;
    repeat (4) @(negedge clk);
    check("R9", fsync, 1'b0);           // held in reset despite inv
    rst = 0; fs_inv = 0; fs_en = 0;
    @(negedge clk);
    check("R9", fsync, 1'b0);

    // Table-driven walk over mode combinations
    for (int v = 0; v < NV; v++) begin
      logic en, inv, pm, fall, q;
      int bad = 0, bad_m = 0;
      logic bad_a = 0, bad_e = 0;
      {en, inv, pm, fall, q} = VEC[v];
      @(negedge clk);
      fs_en = en; fs_inv = inv; fs_pulse = pm; fs_at_fall = fall;
      strobe(1'b1, r1);
      repeat (12) @(negedge clk);
      strobe(q, r2);
      rf = q ? r2 : r1;
      for (int i = 0; i < 2 * DIV + 8; i++) begin
        logic e;
        @(negedge clk);
        e = exp_out(cyc, rf, en, inv, pm, fall);
        if (fsync !== e && bad == 0) begin bad_m = cyc; bad_a = fsync; bad_e = e; end
        if (fsync !== e) bad++;
      end
      if (!en) tag = "R3";
      else if (!q) tag = "R8";
      else if (pm && fall) tag = "R6";
      else if (pm && !inv) tag = "R5";
      else tag = "R4";
      total++;
      if (bad == 0) passed++;
      else $display("FAIL %s vector %0d: fsync=%b expected %b at cycle %0d",
                    tag, v, bad_a, bad_e, bad_m);
    end

    // Directed: square phase after a qualified strobe
    @(negedge clk);
    fs_en = 1; fs_inv = 0; fs_pulse = 0; fs_at_fall = 0;
    strobe(1'b1, r1);
    wait_to(r1 + 1);        check("R7", fsync, 1'b1);
    wait_to(r1 + HALF);     check("R2", fsync, 1'b1);
    wait_to(r1 + HALF + 1); check("R2", fsync, 1'b0);
    wait_to(r1 + DIV);      check("R1", fsync, 1'b0);
    wait_to(r1 + DIV + 1);  check("R1", fsync, 1'b1);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule